// File: doc/BRIEF.md
# Dual-Channel Digital Potentiometer Serial Control Core

This block is the digital heart of a two-channel, 256-step digital potentiometer. A host talks to it through a serial slave port with a select line, a serial clock, data in and data out. Sixteen-bit frames are shifted into a shift register while the select line is low. The frame is acted on only when the select line goes high again. The block holds one 8-bit tap code per channel. For each channel it also drives a pair of switch controls: one opens the top terminal of the resistor ladder, the other ties the wiper to the bottom terminal.

The shift register also serves as a 16-bit delay line, so several devices can be chained from one host. An active-low reset pin returns both tap codes to mid-scale. Shutdown comes from two sources: a serial command, or an active-low pin. It isolates the ladder but still accepts tap writes, so a channel comes out of shutdown at the code most recently written. All serial pins are sampled on the system clock, which must run well above the serial clock.

A frame is a command byte followed by a data byte, sent most significant bit first. In the command byte, bits 5:4 hold the operation: 01 writes the tap code, 10 enters shutdown, and 00 and 11 do nothing. Bit 0 selects channel 0 and bit 1 selects channel 1.

Top module: `spi_dual_wiper_ctrl`

## Requirements
- R1: After the system reset both tap codes read 80h, no channel is in shutdown, and the serial output is low.
- R2: Data in is taken on each rising serial clock edge while select is low. A 16-bit frame with operation 01 (frame bits 13:12) loads the data byte (frame bits 7:0) into every channel whose select bit is set (frame bit 8 for channel 0, bit 9 for channel 1), on the cycle after select rises. Unselected channels keep their code.
- R3: The serial output changes only on falling serial clock edges. After select falls, a downstream device sampling on rising edges reads 16 zeros and then the bits that came in on data in, in order.
- R4: The serial output is driven low whenever select is high.
- R5: A frame is acted on only if the number of rising serial clock edges during the select-low period is a non-zero multiple of 16. In that case the last 16 bits shifted in form the frame. Any other count is discarded.
- R6: Operation 10 puts the selected channels in shutdown, with both switch controls of those channels high. A later operation 01 to a channel takes it out of shutdown.
- R7: While the shutdown pin is low, both channels show shutdown. When the pin is released, each channel shows its own command-driven state again.
- R8: A tap write issued during shutdown updates the code at once, and that code stays in force when shutdown ends.
- R9: One clock cycle after the reset pin is sampled low, both tap codes are 80h. This also applies when a write is executed in that same cycle.
- R10: Serial clock and data activity while select is high changes nothing. Operations 00 and 11 leave codes and shutdown state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low system reset |
| cs_n | input | 1 | Active-low serial select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hw_rst_n | input | 1 | Active-low pin that returns tap codes to mid-scale |
| hw_shdn_n | input | 1 | Active-low shutdown pin for all channels |
| so | output | 1 | Serial data out for chaining |
| wiper | output | NCH*CODE_W | Tap codes, channel 0 in the low byte |
| open_a | output | NCH | Per channel: open the top terminal |
| tie_wb | output | NCH | Per channel: tie wiper to bottom terminal |

## Verification
The bench builds the block with its default values: two channels and 8-bit codes, which gives a 16-bit frame. With two channels, every select pattern can be driven: one channel, the other, both, and none. The 16-bit frame keeps short, long and double-length frames cheap to send, so the 16-zero chain delay and the "last 16 bits win" rule are both exercised on every frame. Mid-scale 80h can be told apart from every data value used in the bench.

// File: rtl/spi_dual_wiper_ctrl.sv
module spi_dual_wiper_ctrl #(
  parameter int NCH    = 2,
  parameter int CODE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    sck,
  input  logic                    si,
  input  logic                    hw_rst_n,
  input  logic                    hw_shdn_n,
  output logic                    so,
  output logic [NCH*CODE_W-1:0]   wiper,
  output logic [NCH-1:0]          open_a,
  output logic [NCH-1:0]          tie_wb
);
  localparam int FRAME_W = 8 + CODE_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_SHDN  = 2'b10;

  logic               sck_q, cs_q, so_q, full;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sr;
  logic [NCH-1:0]     sw_off;
  logic               sck_rise, sck_fall, cs_fall, cs_rise, exec;
  logic [1:0]         op;
  logic [NCH-1:0]     sel;
  logic [CODE_W-1:0]  data;

  assign sck_rise = ~cs_n & sck & ~sck_q;
  assign sck_fall = ~cs_n & ~sck & sck_q;
  assign cs_fall  = ~cs_n & cs_q;
  assign cs_rise  = cs_n & ~cs_q;
  assign op       = sr[FRAME_W-3:FRAME_W-4];
  assign sel      = sr[CODE_W+NCH-1:CODE_W];
  assign data     = sr[CODE_W-1:0];
  assign exec     = cs_rise & full & (cnt == '0);
  assign so       = ~cs_n & so_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cs_fall) begin
      sr   <= '0;
      cnt  <= '0;
      full <= 1'b0;
      so_q <= 1'b0;
    end else begin
      if (sck_rise) begin
        sr <= {sr[FRAME_W-2:0], si};
        if (cnt == CNT_W'(FRAME_W-1)) begin
          cnt  <= '0;
          full <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (sck_fall) so_q <= sr[FRAME_W-1];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CODE_W-1:0] code;

    always_ff @(posedge clk) begin
      if (!rst_n || !hw_rst_n)
        code <= MID;
      else if (exec && sel[ch] && op == OP_WRITE)
        code <= data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        sw_off[ch] <= 1'b0;
      else if (exec && sel[ch]) begin
        if (op == OP_WRITE)     sw_off[ch] <= 1'b0;
        else if (op == OP_SHDN) sw_off[ch] <= 1'b1;
      end
    end

    assign wiper[ch*CODE_W +: CODE_W] = code;
    assign open_a[ch] = sw_off[ch] | ~hw_shdn_n;
    assign tie_wb[ch] = sw_off[ch] | ~hw_shdn_n;
  end
endmodule

module spi_dual_wiper_ctrl_chk #(
  parameter int NCH    = 2,
  parameter int CODE_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  hw_rst_n,
  input logic                  hw_shdn_n,
  input logic                  so,
  input logic [NCH*CODE_W-1:0] wiper,
  input logic [NCH-1:0]        open_a,
  input logic [NCH-1:0]        tie_wb
);
  localparam logic [NCH*CODE_W-1:0] ALL_MID = {NCH{1'b1, {(CODE_W-1){1'b0}}}};

  a_r4_so_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !so);

  a_r9_reset_midscale: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_rst_n |=> wiper == ALL_MID);

  a_r7_pin_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_shdn_n |-> (&open_a && &tie_wb));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n, 1) && $past(cs_n, 2) && $past(hw_rst_n)) |-> $stable(wiper));
endmodule

bind spi_dual_wiper_ctrl spi_dual_wiper_ctrl_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hw_rst_n(hw_rst_n), .hw_shdn_n(hw_shdn_n),
  .so(so), .wiper(wiper), .open_a(open_a), .tie_wb(tie_wb));

// File: tb/tb_spi_dual_wiper_ctrl.sv
`timescale 1ns/1ps
module tb_spi_dual_wiper_ctrl;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, hw_rst_n = 1, hw_shdn_n = 1;
  logic so;
  logic [15:0] wiper;
  logic [1:0] open_a, tie_wb;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_dual_wiper_ctrl dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hw_rst_n(hw_rst_n), .hw_shdn_n(hw_shdn_n), .so(so), .wiper(wiper),
    .open_a(open_a), .tie_wb(tie_wb));

  // behavioural reference
  bit b[$];
  logic [7:0] m_code[2];
  bit m_off[2];
  bit m_so, p_sck, p_cs;

  always @(posedge clk) begin
    if (!rst_n) begin
      b.delete(); m_code[0] = 8'h80; m_code[1] = 8'h80; m_off[0] = 0; m_off[1] = 0;
      m_so = 0; p_sck = 0; p_cs = 1;
    end else begin
      if (!cs_n && p_cs) begin b.delete(); m_so = 0; end
      else if (!cs_n && sck && !p_sck) b.push_back(si);
      else if (!cs_n && !sck && p_sck) m_so = (b.size() >= 16) ? b[b.size()-16] : 1'b0;
      if (cs_n && !p_cs && b.size() > 0 && b.size() % 16 == 0) begin
        logic [15:0] f;
        for (int k = 0; k < 16; k++) f[15-k] = b[b.size()-16+k];
        for (int c = 0; c < 2; c++) if (f[8+c]) begin
          if (f[13:12] == 2'b01) begin
            if (hw_rst_n) m_code[c] = f[7:0];
            m_off[c] = 0;
          end else if (f[13:12] == 2'b10) m_off[c] = 1;
        end
      end
      if (!hw_rst_n) begin m_code[0] = 8'h80; m_code[1] = 8'h80; end
      p_sck = sck; p_cs = cs_n;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 wiper model", wiper, {m_code[1], m_code[0]});
    chk("R3 so model", so, cs_n ? 1'b0 : m_so);
    chk("R6 open_a model", open_a, {m_off[1] | !hw_shdn_n, m_off[0] | !hw_shdn_n});
    chk("R6 tie_wb model", tie_wb, {m_off[1] | !hw_shdn_n, m_off[0] | !hw_shdn_n});
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  bit cap[$];
  task automatic send_bit(bit v);
    si = v; step(2);
    cap.push_back(so);
    sck = 1; step(2);
    sck = 0;
  endtask

  task automatic send(logic [31:0] v, int nbits);
    cap.delete();
    cs_n = 0; step(2);
    for (int i = nbits-1; i >= 0; i--) send_bit(v[i]);
    step(2); cs_n = 1; step(3);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(4); rst_n = 1; step(1);
    chk("R1 reset codes", wiper, 16'h8080);
    chk("R1 reset shutdown", open_a, 2'b00);
    chk("R1 reset so", so, 1'b0);

    send(16'h113C, 16);
    chk("R2 write ch0 only", wiper, 16'h803C);
    send(16'h13A5, 16);
    chk("R2 write both", wiper, 16'hA5A5);

    send(16'h2200, 16);
    chk("R6 shutdown ch1", {tie_wb, open_a}, 4'b1010);

    hw_shdn_n = 0; step(2);
    chk("R7 pin shutdown", open_a, 2'b11);
    send(16'h1155, 16);
    chk("R8 write during shutdown", wiper, 16'hA555);
    chk("R7 held during write", open_a, 2'b11);
    hw_shdn_n = 1; step(2);
    chk("R7 release restores own state", open_a, 2'b10);
    chk("R8 new code kept", wiper, 16'hA555);

    send(16'h1211, 16);
    chk("R6 write clears shutdown", open_a, 2'b00);
    chk("R2 write ch1", wiper, 16'h1155);

    send(16'h03EE, 16);
    send(16'h33DD, 16);
    chk("R10 noop codes", wiper, 16'h1155);
    chk("R10 noop shutdown", open_a, 2'b00);

    send(16'h13AA >> 1, 15);
    chk("R5 15-bit frame discarded", wiper, 16'h1155);
    send({16'h13AA, 1'b0}, 17);
    chk("R5 17-bit frame discarded", wiper, 16'h1155);
    send(0, 0);
    chk("R5 empty frame discarded", wiper, 16'h1155);

    send({16'h1101, 16'h1177}, 32);
    chk("R5 32-bit frame last half wins", wiper, 16'h1177);
    begin
      logic [15:0] lead, tail;
      for (int i = 0; i < 16; i++) begin lead[15-i] = cap[i]; tail[15-i] = cap[16+i]; end
      chk("R3 first 16 out are zero", lead, 16'h0000);
      chk("R3 delayed data out", tail, 16'h1101);
    end

    for (int i = 0; i < 20; i++) begin si = i[0]; sck = ~sck; step(2); end
    sck = 0; step(2);
    chk("R10 idle clocks ignored", wiper, 16'h1177);
    chk("R4 so low when deselected", so, 1'b0);

    hw_rst_n = 0; step(1);
    chk("R9 reset pin midscale", wiper, 16'h8080);
    step(3); hw_rst_n = 1; step(2);
    chk("R9 midscale held after release", wiper, 16'h8080);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule